// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables held in memory. A caller presents a virtual address together with the physical base of the current context's top-level directory. The walker reads one 32-bit directory entry, which names the frame of a second-level table, then reads one entry from that table, which names the frame of the target page. The physical address returned is that page frame joined to the untouched 12-bit page offset.

Each entry is judged before it is used. An entry whose valid flag is clear is reported as an access violation, with separate codes for the directory level and the table level. An entry that is valid but whose present flag is clear is reported as a page fault, meaning the mapping exists but no physical memory currently backs it. The walker handles one translation at a time, reads memory through a valid/ready request channel with a separate read-data-valid return, and announces each result with a one-cycle done pulse while holding the result steady until the next one.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, mem_req_valid is 0, done is 0, done_paddr is 0 and done_fault is 00.
- R2: req_ready is 1 only while no walk is in progress and not in the cycle done is high; a request is taken in a cycle where req_valid and req_ready are both 1, and a request held high during a walk is taken only after that walk's done pulse.
- R3: The first read of a walk goes to {root_base[31:12], 12'h000} + 4 * va[31:22]; root_base bits [11:0] are ignored, and root_base and req_vaddr are sampled only in the cycle the request is taken.
- R4: The second read goes to {E1[31:12], 12'h000} + 4 * va[21:12], where E1 is the directory entry returned by the first read; it is issued only when E1 bit 0 (valid) and bit 1 (present) are both 1.
- R5: mem_req_valid stays high with mem_req_addr unchanged until mem_req_ready is seen high; each level issues exactly one read.
- R6: When both entries are valid and present, done_paddr is {E2[31:12], va[11:0]} with E2 the second-level entry, and done_fault is 00.
- R7: A directory entry with bit 0 clear ends the walk after one read with done_fault 01.
- R8: A second-level entry with bit 0 clear ends the walk with done_fault 10.
- R9: An entry at either level with bit 0 set and bit 1 clear ends the walk with done_fault 11; an entry with bit 0 clear reports an access violation whatever bit 1 holds.
- R10: done is high for exactly one cycle per walk; done_paddr and done_fault change only at a done pulse and are then held; on any nonzero fault done_paddr is 0.
- R11: mem_rsp_valid is ignored whenever no read is outstanding (while idle, or while a read request is still waiting for mem_req_ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Physical address of the top-level directory for the current context |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical address of the entry word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle pulse marking a finished walk |
| done_paddr | output | 32 | Translated physical address, 0 on a fault |
| done_fault | output | 2 | 00 ok, 01 directory access violation, 10 table access violation, 11 page fault |

## Verification
Two things can coincide in one cycle: the done pulse that closes a walk and the arrival of the next request, which the caller may already be holding high. The bench keeps a second request asserted throughout a walk, checks that req_ready stays low through every busy cycle and through the done cycle, and then confirms that the first result is reported unchanged and that the held request starts a fresh walk whose addresses and result belong to the second virtual address. The same overlap is provoked on the memory side by raising mem_rsp_valid with an invalid entry while a read request is still stalled, and the walk must finish as if that beat never came.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    parameter int unsigned PA_W       = 32;
    parameter int unsigned VA_W       = 32;
    parameter int unsigned DIR_IDX_W  = 10;
    parameter int unsigned TBL_IDX_W  = 10;
    parameter int unsigned OFS_W      = 12;
    parameter int unsigned ENT_SHIFT  = 2;
    parameter int unsigned VALID_POS  = 0;
    parameter int unsigned PRESENT_POS = 1;

    localparam int unsigned FRAME_W = PA_W - OFS_W;

    typedef enum logic [1:0] {
        FLT_OK     = 2'b00,
        FLT_AV_DIR = 2'b01,
        FLT_AV_TBL = 2'b10,
        FLT_PAGE   = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_READ_DIR = 2'd1,
        WS_READ_PT  = 2'd2,
        WS_DONE     = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        EV_INVALID = 2'd0,
        EV_ABSENT  = 2'd1,
        EV_USABLE  = 2'd2
    } entry_verdict_e;

    typedef struct packed {
        logic [DIR_IDX_W-1:0] dir_idx;
        logic [TBL_IDX_W-1:0] tbl_idx;
        logic [OFS_W-1:0]     ofs;
    } va_fields_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        entry_verdict_e     verdict;
    } entry_info_t;

    function automatic logic [PA_W-1:0] entry_addr(
        input logic [FRAME_W-1:0] frame,
        input logic [PA_W-1:0]    idx
    );
        logic [PA_W-1:0] base;
        base = {frame, {OFS_W{1'b0}}};
        return base + (idx << ENT_SHIFT);
    endfunction

endpackage

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
    import ptw_pkg::*;
#(
    parameter int unsigned ENT_W = PA_W
) (
    input  logic [ENT_W-1:0] entry,
    output entry_info_t      info
);
    localparam int unsigned FRAME_LSB = OFS_W;

    always_comb begin
        info.frame = entry[ENT_W-1:FRAME_LSB];
        if (!entry[VALID_POS]) begin
            info.verdict = EV_INVALID;
        end else if (!entry[PRESENT_POS]) begin
            info.verdict = EV_ABSENT;
        end else begin
            info.verdict = EV_USABLE;
        end
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int unsigned LEVELS = 2
) (
    input  logic               level_sel,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  va_fields_t         va,
    output logic [PA_W-1:0]    addr
);
    logic [PA_W-1:0] lvl_addr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        if (g == 0) begin : g_dir
            assign lvl_addr[g] = entry_addr(root_frame, PA_W'(va.dir_idx));
        end else begin : g_tbl
            assign lvl_addr[g] = entry_addr(tbl_frame, PA_W'(va.tbl_idx));
        end
    end

    assign addr = level_sel ? lvl_addr[1] : lvl_addr[0];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           mem_req_ready,
    input  logic           mem_rsp_valid,
    input  entry_verdict_e verdict,
    output logic           req_ready,
    output logic           accept,
    output logic           mem_req_valid,
    output logic           level_sel,
    output logic           load_tbl,
    output logic           finish,
    output fault_e         fault,
    output logic           done
);
    walk_state_e state_q, state_d;
    logic        issued_q;
    logic        in_read;
    logic        rsp_take;

    assign req_ready     = (state_q == WS_IDLE);
    assign accept        = req_valid && req_ready;
    assign in_read       = (state_q == WS_READ_DIR) || (state_q == WS_READ_PT);
    assign mem_req_valid = in_read && !issued_q;
    assign rsp_take      = in_read && issued_q && mem_rsp_valid;
    assign level_sel     = (state_q == WS_READ_PT);
    assign done          = (state_q == WS_DONE);

    always_comb begin
        state_d  = state_q;
        load_tbl = 1'b0;
        finish   = 1'b0;
        fault    = FLT_OK;
        unique case (state_q)
            WS_IDLE: begin
                if (accept) begin
                    state_d = WS_READ_DIR;
                end
            end
            WS_READ_DIR: begin
                if (rsp_take) begin
                    unique case (verdict)
                        EV_USABLE: begin
                            state_d  = WS_READ_PT;
                            load_tbl = 1'b1;
                        end
                        EV_ABSENT: begin
                            state_d = WS_DONE;
                            finish  = 1'b1;
                            fault   = FLT_PAGE;
                        end
                        default: begin
                            state_d = WS_DONE;
                            finish  = 1'b1;
                            fault   = FLT_AV_DIR;
                        end
                    endcase
                end
            end
            WS_READ_PT: begin
                if (rsp_take) begin
                    state_d = WS_DONE;
                    finish  = 1'b1;
                    unique case (verdict)
                        EV_USABLE: fault = FLT_OK;
                        EV_ABSENT: fault = FLT_PAGE;
                        default:   fault = FLT_AV_TBL;
                    endcase
                end
            end
            default: begin
                state_d = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WS_IDLE;
            issued_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mem_req_valid && mem_req_ready) begin
                issued_q <= 1'b1;
            end else if (rsp_take) begin
                issued_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PA_W-1:0] root_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic [PA_W-1:0] done_paddr,
    output logic [1:0]      done_fault
);
    va_fields_t         va_q;
    logic [FRAME_W-1:0] root_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [PA_W-1:0]    paddr_q;
    fault_e             fault_q;

    entry_info_t ent_info;
    logic        accept;
    logic        level_sel;
    logic        load_tbl;
    logic        finish;
    fault_e      fault;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .verdict       (ent_info.verdict),
        .req_ready     (req_ready),
        .accept        (accept),
        .mem_req_valid (mem_req_valid),
        .level_sel     (level_sel),
        .load_tbl      (load_tbl),
        .finish        (finish),
        .fault         (fault),
        .done          (done)
    );

    ptw_entry_chk #(.ENT_W(PA_W)) u_entry (
        .entry (mem_rsp_data),
        .info  (ent_info)
    );

    ptw_addr_gen #(.LEVELS(2)) u_addr (
        .level_sel  (level_sel),
        .root_frame (root_frame_q),
        .tbl_frame  (tbl_frame_q),
        .va         (va_q),
        .addr       (mem_req_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q         <= '0;
            root_frame_q <= '0;
            tbl_frame_q  <= '0;
            paddr_q      <= '0;
            fault_q      <= FLT_OK;
        end else begin
            if (accept) begin
                va_q         <= va_fields_t'(req_vaddr);
                root_frame_q <= root_base[PA_W-1:OFS_W];
            end
            if (load_tbl) begin
                tbl_frame_q <= ent_info.frame;
            end
            if (finish) begin
                fault_q <= fault;
                paddr_q <= (fault == FLT_OK) ? {ent_info.frame, va_q.ofs} : '0;
            end
        end
    end

    assign done_paddr = paddr_q;
    assign done_fault = fault_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [PA_W-1:0] root_base,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            done,
    input logic [PA_W-1:0] done_paddr,
    input logic [1:0]      done_fault
);
    logic [VA_W-1:0] cap_va;
    logic [PA_W-1:0] cap_base;
    logic [2:0]      rd_cnt;
    logic [PA_W-1:0] exp_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_va   <= '0;
            cap_base <= '0;
            rd_cnt   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                cap_va   <= req_vaddr;
                cap_base <= root_base;
                rd_cnt   <= '0;
            end else if (mem_req_valid && mem_req_ready) begin
                rd_cnt <= rd_cnt + 3'd1;
            end
        end
    end

    assign exp_first = {cap_base[PA_W-1:OFS_W], {OFS_W{1'b0}}}
                     + {{(PA_W-DIR_IDX_W-ENT_SHIFT){1'b0}},
                        cap_va[VA_W-1 -: DIR_IDX_W], {ENT_SHIFT{1'b0}}};

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !done));

    assert_first_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_req_valid && mem_req_addr == exp_first));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_read_bound_R5: assert property (@(posedge clk) disable iff (rst)
        rd_cnt <= 3'd2);

    assert_ofs_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault == 2'b00) |-> (done_paddr[OFS_W-1:0] == cap_va[OFS_W-1:0] && rd_cnt == 3'd2));

    assert_dir_av_one_read_R7: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault == 2'b01) |-> (rd_cnt == 3'd1));

    assert_tbl_av_two_reads_R8: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault == 2'b10) |-> (rd_cnt == 3'd2));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(done_paddr) && $stable(done_fault)));

    assert_fault_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault != 2'b00) |-> (done_paddr == '0));
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .root_base     (root_base),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .done_paddr    (done_paddr),
    .done_fault    (done_fault)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] root_base;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pt_walker dut_i (
        .clk           (clk),
        .rst           (rst),
        .root_base     (root_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .done_paddr    (done_paddr),
        .done_fault    (done_fault)
    );

    // memory model state
    logic [31:0] m_a [16];
    logic [31:0] m_d [16];
    int          m_n;
    int          stall_cfg;
    int          stall_cnt;
    bit          glitch_cfg;
    bit          rsp_due;
    logic [31:0] rsp_addr;
    logic [31:0] log_a [4];
    int          log_n;
    int          busy_ready;
    bit          ready_at_done;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mem_clear();
        m_n = 0;
    endtask

    task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
        m_a[m_n] = a;
        m_d[m_n] = d;
        m_n++;
    endtask

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        logic [31:0] r = 32'h0;
        for (int i = 0; i < m_n; i++) begin
            if (m_a[i] == a) r = m_d[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] dir_addr(input logic [31:0] base, input logic [31:0] va);
        return {base[31:12], 12'h000} + ({22'h0, va[31:22]} * 4);
    endfunction

    function automatic logic [31:0] tbl_addr(input logic [31:0] ent, input logic [31:0] va);
        return {ent[31:12], 12'h000} + ({22'h0, va[21:12]} * 4);
    endfunction

    // one negedge step of the memory model
    task automatic mem_step();
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_data  = 32'h0;
        if (rsp_due) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_get(rsp_addr);
            rsp_due       = 1'b0;
        end else if (mem_req_valid) begin
            if (stall_cnt >= stall_cfg) begin
                mem_req_ready = 1'b1;
                rsp_addr      = mem_req_addr;
                if (log_n < 4) log_a[log_n] = mem_req_addr;
                log_n++;
                rsp_due   = 1'b1;
                stall_cnt = 0;
            end else begin
                stall_cnt++;
                if (glitch_cfg) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = 32'h0;
                end
            end
        end
    endtask

    task automatic await_result(input bit taken, input bit keep_req, input logic [31:0] va_next,
                                input logic [31:0] base, output logic [31:0] pa,
                                output logic [1:0] flt);
        bit got = 0;
        bit acc = 0;
        log_n = 0; stall_cnt = 0; rsp_due = 0; busy_ready = 0;
        pa = 32'hx; flt = 2'bx;
        if (taken) begin
            @(negedge clk);
            acc = 1;
        end
        for (int k = 0; k < 300 && !got; k++) begin
            if (acc) begin
                root_base = ~base;
                if (keep_req) req_vaddr = va_next;
                else begin req_valid = 1'b0; req_vaddr = ~va_next; end
            end
            mem_step();
            if (done) begin
                got = 1;
                pa = done_paddr;
                flt = done_fault;
                ready_at_done = req_ready;
            end else begin
                if (acc && req_ready) busy_ready++;
                if (req_valid && req_ready) acc = 1;
                @(negedge clk);
            end
        end
        if (!got) chk("watchdog walk R10", 32'd0, 32'd1);
        // cycle after the done pulse
        @(negedge clk);
        mem_step();
        chk("R10 done one cycle", {31'h0, done}, 32'h0);
        chk("R10 paddr held", done_paddr, pa);
        chk("R10 fault held", {30'h0, done_fault}, {30'h0, flt});
        chk("R2 ready after done", {31'h0, req_ready}, 32'h1);
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input int stall,
                            output logic [31:0] pa, output logic [1:0] flt);
        stall_cfg = stall;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        root_base = base;
        await_result(0, 0, va, base, pa, flt);
        chk("R2 ready low while busy", busy_ready, 0);
    endtask

    task automatic t_reset();
        chk("R1 ready in reset", {31'h0, req_ready}, 32'h1);
        chk("R1 mem idle in reset", {31'h0, mem_req_valid}, 32'h0);
        chk("R1 done low", {31'h0, done}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 paddr zero", done_paddr, 32'h0);
        chk("R1 fault zero", {30'h0, done_fault}, 32'h0);
        chk("R1 ready after reset", {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_basic();
        logic [31:0] va = 32'h1234_5678, base = 32'h0001_0ABC, e1 = 32'h0002_0003, e2 = 32'hABCD_E003;
        logic [31:0] pa; logic [1:0] f;
        mem_clear();
        mem_put(dir_addr(base, va), e1);
        mem_put(tbl_addr(e1, va), e2);
        glitch_cfg = 0;
        run_walk(va, base, 0, pa, f);
        chk("R5 two reads", log_n, 2);
        chk("R3 dir address", log_a[0], dir_addr(base, va));
        chk("R4 table address", log_a[1], tbl_addr(e1, va));
        chk("R6 paddr", pa, {e2[31:12], va[11:0]});
        chk("R6 fault ok", {30'h0, f}, 32'h0);
    endtask

    task automatic t_stall_glitch();
        logic [31:0] va = 32'hFFFF_F001, base = 32'hFFFF_0FFF, e1 = 32'h7000_1007, e2 = 32'h0000_1FFB;
        logic [31:0] pa; logic [1:0] f;
        mem_clear();
        mem_put(dir_addr(base, va), e1);
        mem_put(tbl_addr(e1, va), e2);
        glitch_cfg = 1;
        run_walk(va, base, 3, pa, f);
        glitch_cfg = 0;
        chk("R5 two reads stalled", log_n, 2);
        chk("R3 dir address top index", log_a[0], dir_addr(base, va));
        chk("R4 table address top index", log_a[1], tbl_addr(e1, va));
        chk("R11 stray data ignored paddr", pa, {e2[31:12], va[11:0]});
        chk("R11 stray data ignored fault", {30'h0, f}, 32'h0);
    endtask

    task automatic t_fault(input string tag, input logic [31:0] e1, input logic [31:0] e2,
                           input int reads, input logic [1:0] exp_f);
        logic [31:0] va = 32'h8040_3ABC, base = 32'h0040_0000;
        logic [31:0] pa; logic [1:0] f;
        mem_clear();
        mem_put(dir_addr(base, va), e1);
        mem_put(tbl_addr(e1, va), e2);
        run_walk(va, base, 1, pa, f);
        chk({tag, " fault code"}, {30'h0, f}, {30'h0, exp_f});
        chk({tag, " paddr zero R10"}, pa, 32'h0);
        chk({tag, " read count"}, log_n, reads);
    endtask

    task automatic t_back_to_back();
        logic [31:0] va1 = 32'h0040_1111, va2 = 32'h00C0_2222, base = 32'h0003_0000;
        logic [31:0] e1a = 32'h0005_0003, e2a = 32'h1111_1003;
        logic [31:0] e1b = 32'h0006_0003, e2b = 32'h2222_2003;
        logic [31:0] pa; logic [1:0] f;
        mem_clear();
        mem_put(dir_addr(base, va1), e1a);
        mem_put(tbl_addr(e1a, va1), e2a);
        mem_put(dir_addr(base, va2), e1b);
        mem_put(tbl_addr(e1b, va2), e2b);
        stall_cfg = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va1;
        root_base = base;
        await_result(0, 1, va2, base, pa, f);
        chk("R2 held request not taken while busy", busy_ready, 0);
        chk("R2 not ready in done cycle", {31'h0, ready_at_done}, 32'h0);
        chk("R6 first result", pa, {e2a[31:12], va1[11:0]});
        // second walk: the held request is taken at the next edge, base register restored
        root_base = base;
        await_result(1, 0, va2, base, pa, f);
        chk("R3 second walk dir address", log_a[0], dir_addr(base, va2));
        chk("R4 second walk table address", log_a[1], tbl_addr(e1b, va2));
        chk("R6 second result", pa, {e2b[31:12], va2[11:0]});
        chk("R6 second fault", {30'h0, f}, 32'h0);
    endtask

    task automatic t_idle_rsp();
        logic [31:0] pa_before = done_paddr;
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h0000_0003;
        @(negedge clk);
        mem_rsp_data  = 32'h0000_0000;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk("R11 idle rsp no done", {31'h0, done}, 32'h0);
        chk("R11 idle rsp ready", {31'h0, req_ready}, 32'h1);
        chk("R11 idle rsp no read", {31'h0, mem_req_valid}, 32'h0);
        chk("R11 idle rsp paddr held", done_paddr, pa_before);
    endtask

    initial begin
        rst = 1'b1;
        root_base = 32'h0; req_valid = 1'b0; req_vaddr = 32'h0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
        m_n = 0; stall_cfg = 0; stall_cnt = 0; glitch_cfg = 0; rsp_due = 0; log_n = 0;
        busy_ready = 0; ready_at_done = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_stall_glitch();
        t_fault("R7 dir invalid",            32'h0002_0000, 32'hFFFF_F003, 1, 2'b01);
        t_fault("R9 dir valid not present",  32'h0002_0001, 32'hFFFF_F003, 1, 2'b11);
        t_fault("R8 table invalid",          32'h0002_0003, 32'h1234_5000, 2, 2'b10);
        t_fault("R9 table valid not present", 32'h0002_0003, 32'h1234_5001, 2, 2'b11);
        t_fault("R9 table present bit only", 32'h0002_0003, 32'h1234_5002, 2, 2'b10);
        t_fault("R9 dir present bit only",   32'h0002_0002, 32'h1234_5003, 1, 2'b01);
        t_back_to_back();
        t_idle_rsp();
        t_basic();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule